// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

The engine paints a byte range of memory with a repeating pattern element of two, three or four bytes. It has two independent channels, and each one holds its own range, pattern value and element-size setting. Software writes a channel's start and end byte addresses and its pattern first. It then writes the channel's control word with the go bit set. The channel stays pending until the engine has walked the whole range, one 32-bit word per cycle, with per-byte write enables. When the walk ends, the go bit clears, the channel's done flag sets, and the channel's interrupt line pulses.

Elements are laid down back to back from the start address. Every element whose first byte lies below the end address is written in full. Three-byte elements do not line up with 32-bit words, so the engine tracks each word's offset within the pattern. With that offset it rotates the data bytes and picks the byte enables, and a single word write can carry the tail of one element and the head of the next.

The two channels share one walker. When both are pending at the moment the walker is free, channel 0 is served first. Channel 1 waits with its go bit still set.

Top module: `fill_engine`

## Requirements
- R1: A write to register select 3 (control) on a channel loads the element size from bits [2:1] and the go bit from bit 0, and it always clears that channel's done flag. With bit 0 = 0 no fill starts and no memory write follows.
- R2: When the end address is less than or equal to the start address, the fill completes without any memory write.
- R3: Element size code 2'b00 selects 2-byte elements. Writes are issued as consecutive word addresses (byte address / 4) on consecutive cycles. Data is little-endian: pattern byte i occupies data bits [8i+7:8i], and a lane's enable is set only for bytes that belong to an element starting at or after the start address and below the end address.
- R4: Element size code 2'b01 selects 3-byte elements, placed back to back from the start address. The lane at byte address a carries pattern byte ((a - start) mod 3), including across word boundaries.
- R5: Element size codes 2'b10 and 2'b11 select 4-byte elements, and the same lane rule applies for any start alignment.
- R6: On completion the channel's go flag (trig_o) clears and its done flag (fin_o) sets, also when the start address is zero.
- R7: On completion the channel's own irq_o bit pulses for exactly one cycle, unless the start address is zero, in which case no pulse occurs.
- R8: When both channels are pending while the walker is free, all of channel 0's writes come before any of channel 1's. Channel 1 keeps trig_o set until its own fill ends.
- R9: Register writes to a channel whose go flag is set are ignored. A later fill on that channel uses the values held before the ignored writes.
- R10: After reset, trig_o, fin_o, irq_o and mem_we are all zero.

Register selects: 0 = start byte address, 1 = end byte address (exclusive), 2 = pattern value, 3 = control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NCH | Per-channel register write strobe; several bits may be set together |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| trig_o | output | NCH | Per-channel go (pending/active) flag |
| fin_o | output | NCH | Per-channel done flag |
| irq_o | output | NCH | Per-channel completion pulse |
| mem_we | output | 1 | Memory word write strobe |
| mem_waddr | output | AW-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |

## Verification
Fills are driven with each element size, with aligned and unaligned start addresses, and with end addresses that cut an element in the middle. These cases separate correct lane rotation and enable masks from off-by-one or wrong-phase errors. The 3-byte runs that start at offsets 1 and 2 of a word expose any mistake in phase tracking across words. Zero-length, reversed and zero-start ranges separate the write path from the completion and interrupt path. A joint trigger of both channels, and register writes made during an active fill, show the order of service and the register lock.

// File: rtl/fill_pkg.sv
package fill_pkg;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_END   = 2'd1;
  localparam logic [1:0] SEL_VALUE = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RUN  = 2'd1,
    W_FIN  = 2'd2
  } walk_state_t;

  // bytes per element for a size code
  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'b00:   elem_bytes = 3'd2;
      2'b01:   elem_bytes = 3'd3;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

  // (p + k) mod sz, with p < sz, k < 4, sz in {2,3,4}
  function automatic logic [1:0] lane_pos(input logic [1:0] p, input logic [1:0] k,
                                          input logic [2:0] sz);
    logic [2:0] s;
    s = {1'b0, p} + {1'b0, k};
    if (s >= sz) s = s - sz;
    if (s >= sz) s = s - sz;
    lane_pos = s[1:0];
  endfunction

  // pattern position of lane 0 of the word holding the start byte
  function automatic logic [1:0] first_phase(input logic [1:0] low, input logic [2:0] sz);
    logic [1:0] r;
    case (sz)
      3'd2: r = {1'b0, low[0]};
      3'd3: begin
        case (low)
          2'd1:    r = 2'd2;
          2'd2:    r = 2'd1;
          default: r = 2'd0;
        endcase
      end
      default: r = 2'd0 - low;
    endcase
    first_phase = r;
  endfunction

  // pattern position of lane 0 one word later
  function automatic logic [1:0] step_phase(input logic [1:0] p, input logic [2:0] sz);
    if (sz == 3'd3) step_phase = (p == 2'd2) ? 2'd0 : p + 2'd1;
    else            step_phase = p;
  endfunction

endpackage

// File: rtl/fill_chan_regs.sv
module fill_chan_regs
  import fill_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          done_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o,
  output logic [31:0]   value_o,
  output logic [1:0]    size_o,
  output logic          trig_o,
  output logic          fin_o
);

  logic accept;
  assign accept = we && !trig_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= '0;
      end_o   <= '0;
      value_o <= '0;
      size_o  <= '0;
      trig_o  <= 1'b0;
      fin_o   <= 1'b0;
    end else begin
      if (accept) begin
        case (sel)
          SEL_START: start_o <= wdata[AW-1:0];
          SEL_END:   end_o   <= wdata[AW-1:0];
          SEL_VALUE: value_o <= wdata;
          default: begin
            size_o <= wdata[2:1];
            trig_o <= wdata[0];
            fin_o  <= 1'b0;
          end
        endcase
      end
      if (done_i) begin
        trig_o <= 1'b0;
        fin_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fill_arb.sv
module fill_arb #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  input  logic           idle,
  output logic           gnt_valid,
  output logic [CW-1:0]  gnt_idx
);

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_valid = idle;
        gnt_idx   = CW'(i);
      end
    end
  end

endmodule

// File: rtl/fill_walk.sv
module fill_walk
  import fill_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WW = AW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [CW-1:0]  go_ch,
  input  logic [AW-1:0]  go_start,
  input  logic [AW-1:0]  go_end,
  input  logic [31:0]    go_value,
  input  logic [1:0]     go_size,
  output logic           idle,
  output logic           done,
  output logic [CW-1:0]  done_ch,
  output logic [NCH-1:0] irq,
  output logic           mem_we,
  output logic [WW-1:0]  mem_waddr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_be
);

  walk_state_t   state;
  logic [WW-1:0] wa;
  logic [1:0]    phase;
  logic [2:0]    sz;
  logic [AW-1:0] st, en;
  logic [31:0]   val;
  logic [CW-1:0] ch;

  logic [3:0]    lane_be;
  logic [31:0]   lane_dat;
  logic [AW:0]   nxt_base;
  logic [1:0]    nxt_phase;
  logic          last_word;
  logic [2:0]    go_sz;

  assign idle    = (state == W_IDLE);
  assign done    = (state == W_FIN);
  assign done_ch = ch;
  assign go_sz   = elem_bytes(go_size);

  always_comb begin
    lane_be  = '0;
    lane_dat = '0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0]  pos;
      logic [AW:0] a;
      logic [AW:0] head;
      pos  = lane_pos(phase, 2'(k), sz);
      a    = {1'b0, wa, 2'(k)};
      head = a - {{(AW-1){1'b0}}, pos};
      lane_be[k]       = (a >= {1'b0, st}) && (head < {1'b0, en});
      lane_dat[8*k +: 8] = 8'(val >> (8 * pos));
    end
    nxt_base  = {1'b0, wa, 2'b00} + (AW+1)'(4);
    nxt_phase = step_phase(phase, sz);
    last_word = (nxt_base - {{(AW-1){1'b0}}, nxt_phase}) >= {1'b0, en};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      wa        <= '0;
      phase     <= '0;
      sz        <= 3'd2;
      st        <= '0;
      en        <= '0;
      val       <= '0;
      ch        <= '0;
      irq       <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= 1'b0;
      irq    <= '0;
      case (state)
        W_IDLE: begin
          if (go) begin
            ch    <= go_ch;
            st    <= go_start;
            en    <= go_end;
            val   <= go_value;
            sz    <= go_sz;
            wa    <= go_start[AW-1:2];
            phase <= first_phase(go_start[1:0], go_sz);
            state <= (go_end > go_start) ? W_RUN : W_FIN;
          end
        end
        W_RUN: begin
          mem_we    <= 1'b1;
          mem_waddr <= wa;
          mem_wdata <= lane_dat;
          mem_be    <= lane_be;
          wa        <= wa + 1'b1;
          phase     <= nxt_phase;
          if (last_word) state <= W_FIN;
        end
        default: begin
          if (st != '0) irq[ch] <= 1'b1;
          state <= W_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 16,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  output logic [NCH-1:0] trig_o,
  output logic [NCH-1:0] fin_o,
  output logic [NCH-1:0] irq_o,
  output logic           mem_we,
  output logic [AW-3:0]  mem_waddr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_be
);

  logic [AW-1:0] c_start [NCH];
  logic [AW-1:0] c_end   [NCH];
  logic [31:0]   c_value [NCH];
  logic [1:0]    c_size  [NCH];
  logic [NCH-1:0] c_done;

  logic          w_idle, w_done, g_valid;
  logic [CW-1:0] w_done_ch, g_idx;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign c_done[c] = w_done && (w_done_ch == CW'(c));
    fill_chan_regs #(.AW(AW)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .we      (cfg_we[c]),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .done_i  (c_done[c]),
      .start_o (c_start[c]),
      .end_o   (c_end[c]),
      .value_o (c_value[c]),
      .size_o  (c_size[c]),
      .trig_o  (trig_o[c]),
      .fin_o   (fin_o[c])
    );
  end

  fill_arb #(.NCH(NCH)) u_arb (
    .req       (trig_o),
    .idle      (w_idle),
    .gnt_valid (g_valid),
    .gnt_idx   (g_idx)
  );

  fill_walk #(.NCH(NCH), .AW(AW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .go        (g_valid),
    .go_ch     (g_idx),
    .go_start  (c_start[g_idx]),
    .go_end    (c_end[g_idx]),
    .go_value  (c_value[g_idx]),
    .go_size   (c_size[g_idx]),
    .idle      (w_idle),
    .done      (w_done),
    .done_ch   (w_done_ch),
    .irq       (irq_o),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );

endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int NCH = 2,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] trig_o,
  input logic [NCH-1:0] fin_o,
  input logic [NCH-1:0] irq_o,
  input logic           mem_we,
  input logic [AW-3:0]  mem_waddr,
  input logic [3:0]     mem_be
);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mem_we && irq_o == '0 && trig_o == '0 && fin_o == '0));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) + 1'b1));

  a_r3_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be != 4'b0000));

  a_r7_irq_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_o));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    a_r6_irq_with_fin: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |-> (fin_o[c] && !trig_o[c]));
    a_r6_fin_on_done: assert property (@(posedge clk) disable iff (rst)
      $rose(fin_o[c]) |-> $fell(trig_o[c]));
    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |=> !irq_o[c]);
  end

endmodule

bind fill_engine fill_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_o    (trig_o),
  .fin_o     (fin_o),
  .irq_o     (irq_o),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .mem_be    (mem_be)
);

// File: tb/fill_engine_tb.sv
module fill_engine_tb;

  localparam int NCH = 2;
  localparam int AW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] cfg_we = '0;
  logic [1:0]     cfg_sel = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [NCH-1:0] trig_o, fin_o, irq_o;
  logic           mem_we;
  logic [AW-3:0]  mem_waddr;
  logic [31:0]    mem_wdata;
  logic [3:0]     mem_be;

  always #2 clk = ~clk;

  fill_engine #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig_o(trig_o), .fin_o(fin_o), .irq_o(irq_o), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  typedef struct {
    int unsigned wa;
    logic [3:0]  be;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  int irq_cnt [NCH];
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    irq_cnt[0] = 0;
    irq_cnt[1] = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) if (irq_o[c]) irq_cnt[c]++;
      if (mem_we) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1 R2 unexpected write", {32'(mem_waddr), mem_wdata}, 64'h0);
        end else begin
          exp_t e;
          logic [31:0] m;
          e = q.pop_front();
          m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
          chk(32'(mem_waddr) == e.wa, {e.tag, " addr"}, 64'(mem_waddr), 64'(e.wa));
          chk(mem_be == e.be, {e.tag, " be"}, 64'(mem_be), 64'(e.be));
          chk((mem_wdata & m) == (e.d & m), {e.tag, " data"},
              64'(mem_wdata & m), 64'(e.d & m));
        end
      end
    end
  end

  // reference model: elements laid back to back while their head is below end
  task automatic push_fill(input int unsigned st, input int unsigned en,
                           input logic [31:0] v, input int s, input string tag);
    int unsigned stop;
    if (en <= st) return;
    stop = st;
    while (stop < en) stop += s;
    for (int unsigned w = st / 4; w <= (stop - 1) / 4; w++) begin
      exp_t e;
      e.wa = w; e.be = '0; e.d = '0; e.tag = tag;
      for (int k = 0; k < 4; k++) begin
        int unsigned a;
        a = w * 4 + k;
        if (a >= st && a < stop) begin
          e.be[k] = 1'b1;
          e.d[8*k +: 8] = v[8*((a - st) % s) +: 8];
        end
      end
      q.push_back(e);
    end
  endtask

  task automatic wr(input logic [NCH-1:0] m, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = m; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (trig_o != '0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int size_of(input logic [1:0] code);
    return (code == 2'b00) ? 2 : (code == 2'b01) ? 3 : 4;
  endfunction

  task automatic fill(input int ch, input int unsigned st, input int unsigned en,
                      input logic [31:0] v, input logic [1:0] code, input string tag);
    logic [NCH-1:0] m;
    int i0;
    m = NCH'(1) << ch;
    i0 = irq_cnt[ch];
    wr(m, 2'd0, st);
    wr(m, 2'd1, en);
    wr(m, 2'd2, v);
    push_fill(st, en, v, size_of(code), tag);
    wr(m, 2'd3, {29'd0, code, 1'b1});
    wait_idle();
    chk(q.size() == 0, {tag, " all writes seen"}, 64'(q.size()), 64'h0);
    chk(!trig_o[ch] && fin_o[ch], "R6 trig clear fin set", {trig_o, fin_o}, 64'h0);
    chk(irq_cnt[ch] - i0 == ((st != 0) ? 1 : 0), "R7 irq count",
        64'(irq_cnt[ch] - i0), 64'((st != 0) ? 1 : 0));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(trig_o == 0 && fin_o == 0 && irq_o == 0 && !mem_we, "R10 reset state",
        {trig_o, fin_o, irq_o, mem_we}, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    fill(0, 32'h100, 32'h10C, 32'h0000_AABB, 2'b00, "R3 aligned 16b");
    fill(0, 32'h202, 32'h207, 32'h0000_1234, 2'b00, "R3 partial 16b");
    fill(1, 32'h301, 32'h30A, 32'h0011_2233, 2'b01, "R4 24b offset1");
    fill(1, 32'h402, 32'h403, 32'h00A1_B2C3, 2'b01, "R4 24b cross word");
    fill(0, 32'h512, 32'h540, 32'h0055_6677, 2'b01, "R4 24b long");
    fill(0, 32'h503, 32'h508, 32'hDEAD_BEEF, 2'b11, "R5 32b unaligned code3");
    fill(1, 32'h600, 32'h60C, 32'h0BAD_F00D, 2'b10, "R5 32b aligned");
    fill(0, 32'h700, 32'h700, 32'h1111_1111, 2'b10, "R2 empty range");
    fill(1, 32'h780, 32'h740, 32'h2222_2222, 2'b00, "R2 reversed range");
    fill(0, 32'h000, 32'h008, 32'h0000_CAFE, 2'b00, "R6 R7 zero start");

    // R1: control write without go bit clears done flag, starts nothing
    wr(2'b01, 2'd3, 32'h0);
    repeat (6) @(negedge clk);
    chk(fin_o[0] == 1'b0 && trig_o[0] == 1'b0, "R1 no-go control write",
        {fin_o[0], trig_o[0]}, 64'h0);

    // R8: joint trigger, channel 0 first
    wr(2'b01, 2'd0, 32'h800); wr(2'b01, 2'd1, 32'h810);
    wr(2'b10, 2'd0, 32'h900); wr(2'b10, 2'd1, 32'h908);
    wr(2'b01, 2'd2, 32'hA0A0_A0A0); wr(2'b10, 2'd2, 32'hB1B1_B1B1);
    push_fill(32'h800, 32'h810, 32'hA0A0_A0A0, 4, "R8 ch0 first");
    push_fill(32'h900, 32'h908, 32'hB1B1_B1B1, 4, "R8 ch1 second");
    wr(2'b11, 2'd3, 32'h5);
    chk(trig_o == 2'b11, "R8 both pending", 64'(trig_o), 64'h3);
    while (!fin_o[0]) @(negedge clk);
    chk(trig_o[1] == 1'b1, "R8 ch1 still pending", 64'(trig_o[1]), 64'h1);
    wait_idle();
    chk(q.size() == 0 && fin_o == 2'b11, "R8 both done", 64'(fin_o), 64'h3);

    // R9: writes during an active fill are ignored
    wr(2'b01, 2'd0, 32'hA00); wr(2'b01, 2'd1, 32'hA40); wr(2'b01, 2'd2, 32'h1357_9BDF);
    push_fill(32'hA00, 32'hA40, 32'h1357_9BDF, 4, "R9 locked regs");
    wr(2'b01, 2'd3, 32'h5);
    wr(2'b01, 2'd2, 32'h0);
    wr(2'b01, 2'd1, 32'hA04);
    wait_idle();
    chk(q.size() == 0, "R9 fill unaffected", 64'(q.size()), 64'h0);
    push_fill(32'hA00, 32'hA40, 32'h1357_9BDF, 4, "R9 retained values");
    wr(2'b01, 2'd3, 32'h5);
    wait_idle();
    chk(q.size() == 0, "R9 retained values all seen", 64'(q.size()), 64'h0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule